// File: doc/BRIEF.md
# Sample-Hold ADC Conversion Sequencer

This block sits between a digital front end and an external sample-and-hold amplifier feeding a 12-bit successive-approximation converter. A request lasting a single clock starts one conversion. The block keeps the amplifier in hold and drives the active-low convert line low for a set number of cycles. The rising edge that ends that low period starts the conversion. The block then watches the converter's busy status. Once busy falls, it waits a settling delay, strobes the result into an output latch and returns an end-of-conversion acknowledge. That acknowledge is registered on the falling clock edge, so a consumer sampling on the rising edge always sees a stable level.

The latched result is shared on a multiplexed bus with a second channel. It is driven onto this block's `data_o` only while the bus select picks the channel, and reads as zero otherwise. The output enable is active low. A parameter inverts the sense of the select, so that two instances can share one select line. Every width of time is a parameter in clock cycles: the stretch of the request, the convert-low time, the latch delay, the acknowledge length and the timeout. The `busy_i` and `sel_i` inputs are taken to be synchronous to `clk`.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst` is high, `hold_o` is 0, `cnv_n_o` is 1, `latch_o` is 0, `eoc_o` is 0, `oe_n_o` is 1 and `data_o` is 0.
- R2: After an accepted request, `hold_o` is 1 from the next edge onward. It stays 1 for at least STRETCH cycles and until `busy_i` has been sampled high.
- R3: After the edge that accepts a request, `cnv_n_o` is 0 for exactly CNV_LOW cycles and then returns to 1. That rising edge is the conversion start.
- R4: In every cycle after an edge where `busy_i` was sampled high, `hold_o` is 1. On the first edge that samples `busy_i` low, with the stretch expired, `hold_o` returns to 0.
- R5: A request that arrives while a conversion is in progress is ignored. `cnv_n_o` makes no second low pulse, so it never falls while busy is high.
- R6: `latch_o` is a single-cycle pulse that rises LAT_DLY edges after the first edge that samples `busy_i` low. On that edge the value of `adc_data_i` is captured.
- R7: `eoc_o` is updated on the falling clock edge. It rises one cycle after the latch pulse and stays high for EOC_LEN cycles.
- R8: With SEL_INV = 0, the channel is selected when `sel_i` = 1; with SEL_INV = 1, when `sel_i` = 0. One edge after selection, `oe_n_o` = 0 and `data_o` holds the latched value. Otherwise `oe_n_o` = 1 and `data_o` = 0.
- R9: The sequencer returns to idle if `busy_i` is not sampled high within TIMEOUT cycles after `cnv_n_o` rises. At that point `hold_o` drops, no latch pulse or acknowledge follows, and the next request is accepted.
- R10: Asserting `rst` forces `eoc_o` low at the next falling edge, even in the middle of an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle conversion request |
| busy_i | input | 1 | Converter busy status |
| adc_data_i | input | DW | Converter parallel result |
| sel_i | input | 1 | Shared bus select |
| hold_o | output | 1 | Sample-and-hold control, 1 = hold |
| cnv_n_o | output | 1 | Active-low convert line; its rise starts a conversion |
| latch_o | output | 1 | Output latch strobe |
| eoc_o | output | 1 | End-of-conversion acknowledge, falling-edge registered |
| oe_n_o | output | 1 | Active-low output enable toward the shared bus |
| data_o | output | DW | Latched result while selected, zero otherwise |

## Verification
Conversions are run with a random delay before busy rises and a random busy length from one to eight cycles. This separates a latch timed from the fall of busy from one timed from the request. Some runs add extra requests during busy, which exposes any convert pulse that could abort a running conversion. Other runs never raise busy, which shows whether the timeout releases hold without a stray latch or acknowledge. A reset in the middle of an acknowledge, and bus reads with the channel selected and then deselected, check that the acknowledge clears and that the bus output is gated.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CNVL,
    S_WRISE,
    S_WFALL,
    S_SETTLE,
    S_LATCH,
    S_ACK
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcseq_down_cnt.sv
module adcseq_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int CNV_LOW = 2,
  parameter int TIMEOUT = 16,
  parameter int LAT_DLY = 2,
  parameter int EOC_LEN = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       busy_i,
  output seq_state_e state_q,
  output seq_state_e nxt_o,
  output logic       accept_o
);

  localparam int MAXV = max2(max2(CNV_LOW, TIMEOUT), max2(LAT_DLY, EOC_LEN));
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] LD_CNV = CW'(CNV_LOW - 1);
  localparam logic [CW-1:0] LD_TMO = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] LD_LAT = CW'(LAT_DLY - 1);
  localparam logic [CW-1:0] LD_EOC = CW'(EOC_LEN - 1);

  logic          ph_load;
  logic [CW-1:0] ph_val;
  logic          ph_zero;

  adcseq_down_cnt #(.W(CW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  always_comb begin
    nxt_o    = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    accept_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        nxt_o    = S_CNVL;
        ph_load  = 1'b1;
        ph_val   = LD_CNV;
        accept_o = 1'b1;
      end
      S_CNVL: if (ph_zero) begin
        nxt_o   = S_WRISE;
        ph_load = 1'b1;
        ph_val  = LD_TMO;
      end
      S_WRISE: begin
        if (busy_i)       nxt_o = S_WFALL;
        else if (ph_zero) nxt_o = S_IDLE;
      end
      S_WFALL: if (!busy_i) begin
        nxt_o   = S_SETTLE;
        ph_load = 1'b1;
        ph_val  = LD_LAT;
      end
      S_SETTLE: if (ph_zero) nxt_o = S_LATCH;
      S_LATCH: begin
        nxt_o   = S_ACK;
        ph_load = 1'b1;
        ph_val  = LD_EOC;
      end
      S_ACK: if (ph_zero) nxt_o = S_IDLE;
      default: nxt_o = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= nxt_o;
  end

endmodule

// File: rtl/adcseq_out.sv
module adcseq_out
  import adcseq_pkg::*;
#(
  parameter int DW      = 12,
  parameter int STRETCH = 3,
  parameter bit SEL_INV = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept_i,
  input  logic          busy_i,
  input  logic          sel_i,
  input  logic [DW-1:0] adc_data_i,
  input  seq_state_e    state_q,
  input  seq_state_e    nxt_i,
  output logic          hold_o,
  output logic          cnv_n_o,
  output logic          latch_o,
  output logic          eoc_o,
  output logic          oe_n_o,
  output logic [DW-1:0] data_o
);

  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [SW-1:0] LD_STR = SW'(STRETCH - 1);

  logic          str_q;
  logic          str_zero;
  logic          str_on;
  logic          chan_sel;
  logic [DW-1:0] lat_q;

  adcseq_down_cnt #(.W(SW)) u_stretch (
    .clk      (clk),
    .rst      (rst),
    .load     (accept_i),
    .load_val (LD_STR),
    .zero     (str_zero)
  );

  assign str_on = accept_i | (str_q & ~str_zero);

  generate
    if (SEL_INV) begin : g_sel_low
      assign chan_sel = ~sel_i;
    end else begin : g_sel_high
      assign chan_sel = sel_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      str_q   <= 1'b0;
      hold_o  <= 1'b0;
      cnv_n_o <= 1'b1;
      latch_o <= 1'b0;
      lat_q   <= '0;
      oe_n_o  <= 1'b1;
      data_o  <= '0;
    end else begin
      str_q   <= str_on;
      hold_o  <= str_on | busy_i | (nxt_i == S_CNVL) | (nxt_i == S_WRISE);
      cnv_n_o <= (nxt_i != S_CNVL);
      latch_o <= (nxt_i == S_LATCH);
      if (nxt_i == S_LATCH) lat_q <= adc_data_i;
      oe_n_o  <= ~chan_sel;
      data_o  <= chan_sel ? lat_q : '0;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) eoc_o <= 1'b0;
    else     eoc_o <= (state_q == S_ACK);
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adcseq_pkg::*;
#(
  parameter int DW      = 12,
  parameter int CNV_LOW = 2,
  parameter int STRETCH = 3,
  parameter int LAT_DLY = 2,
  parameter int EOC_LEN = 3,
  parameter int TIMEOUT = 16,
  parameter bit SEL_INV = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          busy_i,
  input  logic [DW-1:0] adc_data_i,
  input  logic          sel_i,
  output logic          hold_o,
  output logic          cnv_n_o,
  output logic          latch_o,
  output logic          eoc_o,
  output logic          oe_n_o,
  output logic [DW-1:0] data_o
);

  seq_state_e state_q;
  seq_state_e nxt;
  logic       accept;

  adcseq_fsm #(
    .CNV_LOW (CNV_LOW),
    .TIMEOUT (TIMEOUT),
    .LAT_DLY (LAT_DLY),
    .EOC_LEN (EOC_LEN)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .busy_i   (busy_i),
    .state_q  (state_q),
    .nxt_o    (nxt),
    .accept_o (accept)
  );

  adcseq_out #(
    .DW      (DW),
    .STRETCH (STRETCH),
    .SEL_INV (SEL_INV)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .busy_i     (busy_i),
    .sel_i      (sel_i),
    .adc_data_i (adc_data_i),
    .state_q    (state_q),
    .nxt_i      (nxt),
    .hold_o     (hold_o),
    .cnv_n_o    (cnv_n_o),
    .latch_o    (latch_o),
    .eoc_o      (eoc_o),
    .oe_n_o     (oe_n_o),
    .data_o     (data_o)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int DW      = 12,
  parameter int CNV_LOW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_i,
  input logic          hold_o,
  input logic          cnv_n_o,
  input logic          latch_o,
  input logic          eoc_o,
  input logic          oe_n_o,
  input logic [DW-1:0] data_o
);

  localparam int LW = $clog2(CNV_LOW + 2) + 1;
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 low_cnt <= '0;
    else if (cnv_n_o)        low_cnt <= '0;
    else if (low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;
  end

  // R4
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> hold_o);

  // R5
  cnv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> cnv_n_o);

  // R3
  cnv_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv_n_o) |-> (low_cnt == LW'(CNV_LOW)));

  // R6
  latch_single_chk: assert property (@(posedge clk) disable iff (rst)
    latch_o |=> !latch_o);

  // R7
  eoc_after_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_o) |-> eoc_o);

  // R8
  bus_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n_o |-> (data_o == '0));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DW(DW), .CNV_LOW(CNV_LOW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy_i  (busy_i),
  .hold_o  (hold_o),
  .cnv_n_o (cnv_n_o),
  .latch_o (latch_o),
  .eoc_o   (eoc_o),
  .oe_n_o  (oe_n_o),
  .data_o  (data_o)
);

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;

  localparam int DW      = 12;
  localparam int CNV_LOW = 2;
  localparam int STRETCH = 3;
  localparam int LAT_DLY = 2;
  localparam int EOC_LEN = 3;
  localparam int TIMEOUT = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          busy = 1'b0;
  logic          sel = 1'b0;
  logic [DW-1:0] adc = '0;
  logic          hold, cnv_n, latch, eoc, oe_n;
  logic [DW-1:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  adc_conv_seq #(
    .DW(DW), .CNV_LOW(CNV_LOW), .STRETCH(STRETCH), .LAT_DLY(LAT_DLY),
    .EOC_LEN(EOC_LEN), .TIMEOUT(TIMEOUT), .SEL_INV(1'b0)
  ) uut (
    .clk(clk), .rst(rst), .req_i(req), .busy_i(busy), .adc_data_i(adc),
    .sel_i(sel), .hold_o(hold), .cnv_n_o(cnv_n), .latch_o(latch),
    .eoc_o(eoc), .oe_n_o(oe_n), .data_o(dout)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic drv;
    @(posedge clk); #1;
  endtask

  task automatic smp;
    @(negedge clk); #1;
  endtask

  task automatic run_conv(input int dly, input int blen, input logic [DW-1:0] dat,
                          input bit spur, input bit nobusy, input bit rst_ack);
    int low_cnt = 0, r = -1, bstart = 100000, p = -1;
    int lat_at = -1, lat_cnt = 0, eoc_first = -1, eoc_cnt = 0;
    bit prev_busy = 0, hold_bad = 0, pre_bad = 0, busy_seen = 0, done = 0;
    drv; req = 1'b1;
    smp;
    for (int i = 0; i < 300 && !done; i++) begin
      drv;
      req = 1'b0;
      if (rst_ack && eoc_first >= 0) rst = 1'b1;
      if (!nobusy && r >= 0) begin
        busy = (i >= bstart) && (i < bstart + blen);
        if (i == bstart + blen) p = i;
        adc = (i >= bstart + blen) ? dat : DW'($urandom);
      end
      if (spur && busy) req = 1'b1;
      smp;
      if (rst) begin
        chk(eoc == 1'b0, "R10", eoc, 0);
        done = 1;
      end else begin
        if (!cnv_n) low_cnt++;
        if (cnv_n && r < 0 && low_cnt > 0) begin
          r = i;
          bstart = i + 1 + dly;
          chk(r == CNV_LOW, "R3", r, CNV_LOW);
        end
        if (prev_busy && !hold) hold_bad = 1;
        if (!nobusy && !busy_seen && !hold) pre_bad = 1;
        if (prev_busy) busy_seen = 1;
        prev_busy = busy;
        if (p >= 0 && i == p)     chk(hold == 1'b1, "R4", hold, 1);
        if (p >= 0 && i == p + 1) chk(hold == 1'b0, "R4", hold, 0);
        if (latch) begin
          lat_cnt++;
          if (lat_at < 0) lat_at = i;
        end
        if (eoc) begin
          eoc_cnt++;
          if (eoc_first < 0) eoc_first = i;
        end
        if (nobusy && r >= 0 && i == r + TIMEOUT - 1) chk(hold == 1'b1, "R9", hold, 1);
        if (nobusy && r >= 0 && i == r + TIMEOUT)     chk(hold == 1'b0, "R9", hold, 0);
        if (nobusy && r >= 0 && i == r + TIMEOUT + 6) done = 1;
        if (eoc_first >= 0 && !eoc) done = 1;
      end
    end
    busy = 1'b0;
    req = 1'b0;
    if (rst_ack) begin
      drv; rst = 1'b0;
      smp;
    end else begin
      chk(low_cnt == CNV_LOW, "R5", low_cnt, CNV_LOW);
      chk(!hold_bad, "R4", hold_bad, 0);
      if (nobusy) begin
        chk(lat_cnt == 0, "R9", lat_cnt, 0);
        chk(eoc_cnt == 0, "R9", eoc_cnt, 0);
      end else begin
        chk(!pre_bad, "R2", pre_bad, 0);
        chk(lat_cnt == 1, "R6", lat_cnt, 1);
        chk(lat_at == p + LAT_DLY + 1, "R6", lat_at, p + LAT_DLY + 1);
        chk(eoc_first == lat_at + 1, "R7", eoc_first, lat_at + 1);
        chk(eoc_cnt == EOC_LEN, "R7", eoc_cnt, EOC_LEN);
        drv; sel = 1'b1;
        smp;
        drv;
        smp;
        chk(oe_n == 1'b0, "R8", oe_n, 0);
        chk(dout == dat, "R6", dout, dat);
        drv; sel = 1'b0;
        smp;
        drv;
        smp;
        chk(oe_n == 1'b1, "R8", oe_n, 1);
        chk(dout == '0, "R8", dout, 0);
      end
    end
    repeat (2) begin drv; smp; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED_0A1C);
    repeat (3) drv;
    smp;
    // R1 reset state
    chk(hold == 1'b0,  "R1", hold, 0);
    chk(cnv_n == 1'b1, "R1", cnv_n, 1);
    chk(latch == 1'b0, "R1", latch, 0);
    chk(eoc == 1'b0,   "R1", eoc, 0);
    chk(oe_n == 1'b1,  "R1", oe_n, 1);
    chk(dout == '0,    "R1", dout, 0);
    drv; rst = 1'b0;
    smp;

    run_conv(0, 1, 12'hFFF, 1'b0, 1'b0, 1'b0);
    run_conv(3, 8, 12'h001, 1'b0, 1'b0, 1'b0);
    run_conv(2, 4, 12'hA5A, 1'b1, 1'b0, 1'b0);   // R5 extra requests during busy
    run_conv(0, 0, 12'h000, 1'b0, 1'b1, 1'b0);   // R9 busy never rises
    run_conv(1, 3, 12'h123, 1'b0, 1'b0, 1'b0);   // R9 request accepted after timeout
    run_conv(1, 2, 12'h3C3, 1'b0, 1'b0, 1'b1);   // R10 reset during acknowledge
    run_conv(0, 5, 12'h800, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 20; k++) begin
      run_conv(int'($urandom % 5), 1 + int'($urandom % 8), DW'($urandom),
               bit'($urandom % 2), 1'b0, 1'b0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule